// File: doc/BRIEF.md
# Prescaled Real-Time Down Counter

This block is a programmable countdown timer intended to be instantiated several times on a timing board. Software writes a starting value into a load register and sets a run bit in a control register. From then on the live count drops by one on every tick of a prescaler. The tick period is picked by a three-bit resolution code, in decade steps starting at one microsecond, and is derived from a parameterised system clock frequency.

When the count reaches zero the block raises a one-cycle interrupt pulse. It also raises an output strobe, which a separate routing stage can place on an external or distributed line. In one-shot mode the counter then stops with the run bit cleared. In repeat mode the stored load value is put back into the count at the same clock edge, so the timer produces periodic events without software help.

All state can be accessed through a simple register interface with a single-cycle write strobe. Read data is combinational on the address.

Top module: `rt_down_timer`

## Requirements
- R1: After synchronous reset the control word, the load value and the live count all read 0, and `irq` and `out_strobe` are low.
- R2: The tick period is (CLK_FREQ_HZ / 1,000,000) × 10^code clock cycles. The code is control bits 22:20, with codes 0 to 5 giving 1 us to 100 ms. Codes 6 and 7 behave as code 0.
- R3: While running, the count drops by exactly one per tick and is otherwise unchanged. Clearing the run bit holds the count. Starting again continues from the held value.
- R4: When a start write leaves a count of L, `irq` is high for exactly one cycle. That cycle follows the edge L × period cycles after the start write edge, which is the edge at which the count reaches zero.
- R5: Without repeat, the count is 0 after the zero event and control bit 0 (run) reads 0.
- R6: With repeat (control bit 1), the load value is copied into the count at the zero edge, so the count never reads 0, and counting continues with period L × tick. A load value written while running takes effect at the next reload. A load value of zero at reload stops the counter with count 0.
- R7: A write to the load register while stopped also sets the live count. The same write while running leaves the live count unchanged.
- R8: A start write while the count is 0 is refused: the run bit stays 0 and no interrupt follows.
- R9: A start write while already running restarts the prescaler, so the next tick is a full period after that write, and it leaves the count unchanged.
- R10: `out_strobe` pulses together with `irq` when control bit 2 (output enable) is set, and stays low otherwise.
- R11: Register map on `reg_addr`: 0 = control (bit 0 run, bit 1 repeat, bit 2 output enable, bits 22:20 resolution, all other bits read 0), 1 = load value, 2 = live count (writes ignored), 3 = reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_addr | input | 2 | Register address for both write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | One-cycle interrupt pulse at each zero event |
| out_strobe | output | 1 | One-cycle strobe at each zero event when output enable is set |

## Verification
Each resolution code, including the two unused ones, is run with a small load value, and the cycle of the interrupt is measured against load × period. This separates the decade periods from each other and from an off-by-one in the prescaler or count. Repeat runs with a load value changed mid-flight show whether a reload picks up the stored value at the right moment. Stop/resume, restart-while-running and zero-load starts tell prescaler-restart and refusal logic apart from plain counting. Output enable is toggled between otherwise identical runs to isolate the strobe gating.

// File: rtl/rtc_pkg.sv
// Shared constants, register addresses and the decade scale helper for the
// prescaled down counter. Assumes a 32-bit register data path.
package rtc_pkg;

    localparam int DATA_W   = 32;
    localparam int RES_W    = 3;
    localparam int BIT_RUN  = 0;
    localparam int BIT_REP  = 1;
    localparam int BIT_OE   = 2;
    localparam int RES_LSB  = 20;
    localparam int MAX_CODE = 5;

    typedef enum logic [1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_LOAD  = 2'd1,
        ADDR_COUNT = 2'd2,
        ADDR_SPARE = 2'd3
    } reg_addr_e;

    // Decade multiplier for a resolution code; unused codes fall back to 1.
    function automatic int unsigned decade_scale(input logic [RES_W-1:0] code);
        int unsigned s;
        s = 1;
        if (int'(code) > MAX_CODE) begin
            return 1;
        end
        for (int i = 0; i < MAX_CODE; i++) begin
            if (i < int'(code)) begin
                s = s * 10;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/rtc_prescale.sv
// Tick generator: divides the system clock to the period selected by the
// resolution code. Assumes CYC_PER_US >= 1. The divider is held at zero while
// stopped and is cleared by every accepted start, so the first tick arrives a
// full period after the start edge.
module rtc_prescale #(
    parameter int unsigned CYC_PER_US = 200
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run,
    input  logic                     start,
    input  logic [rtc_pkg::RES_W-1:0] res,
    output logic                     tick
);
    localparam int unsigned MAX_PERIOD = CYC_PER_US * 100000;
    localparam int          PW         = $clog2(MAX_PERIOD + 1);
    localparam int          NUM_CODES  = 1 << rtc_pkg::RES_W;

    logic [PW-1:0] per_tab [NUM_CODES];
    logic [PW-1:0] period;
    logic [PW-1:0] div_cnt;

    // One period constant per resolution code.
    for (genvar g = 0; g < NUM_CODES; g++) begin : g_period
        localparam logic [PW-1:0] PER =
            PW'(CYC_PER_US * rtc_pkg::decade_scale(rtc_pkg::RES_W'(g)));
        assign per_tab[g] = PER;
    end

    assign period = per_tab[res];

    // Tick fires in the last cycle of each period while running.
    assign tick = run && (div_cnt >= (period - 1'b1));

    // Divider counter: cleared while stopped, on start and at each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (!run || start || tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rtc_count_core.sv
// Live count register with zero detection, reload and event pulses.
// Assumes run/rep/reload come from the control block and tick from the
// prescaler. The zero event is taken on the tick that sees a count of one.
module rtc_count_core #(
    parameter int COUNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               rep,
    input  logic               oe,
    input  logic               tick,
    input  logic [COUNT_W-1:0] reload,
    input  logic               load_wr,
    input  logic [COUNT_W-1:0] load_data,
    output logic [COUNT_W-1:0] count,
    output logic               halt,
    output logic               irq,
    output logic               out_strobe
);
    logic expire;

    // Zero event and whether it ends the run.
    assign expire = run && tick && (count == COUNT_W'(1));
    assign halt   = expire && (!rep || (reload == '0));

    // Live count: preset while stopped, step or reload while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (!run && load_wr) begin
            count <= load_data;
        end else if (run && tick) begin
            if (count == COUNT_W'(1)) begin
                count <= rep ? reload : '0;
            end else begin
                count <= count - 1'b1;
            end
        end
    end

    // Event pulses, one cycle after the zero edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq        <= 1'b0;
            out_strobe <= 1'b0;
        end else begin
            irq        <= expire;
            out_strobe <= expire && oe;
        end
    end

    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(count)); // R3
    AST_IRQ_AFTER_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(count) == COUNT_W'(1))); // R4
    AST_STOP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && count == COUNT_W'(1) && !rep) |=> (count == '0 && !run)); // R5
    AST_RELOAD_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && count == COUNT_W'(1) && rep && reload != '0)
        |=> (run && count == $past(reload))); // R6
    AST_STROBE_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        out_strobe |-> irq); // R10

endmodule

// File: rtl/rtc_ctrl_regs.sv
// Register block: control fields, load value, start qualification and the
// read mux. Assumes one register access per cycle; read data follows
// reg_addr combinationally.
module rtc_ctrl_regs #(
    parameter int COUNT_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic [1:0]                  reg_addr,
    input  logic [rtc_pkg::DATA_W-1:0]  reg_wdata,
    output logic [rtc_pkg::DATA_W-1:0]  reg_rdata,
    input  logic [COUNT_W-1:0]          count,
    input  logic                        halt,
    output logic                        run,
    output logic                        rep,
    output logic                        oe,
    output logic [rtc_pkg::RES_W-1:0]   res,
    output logic [COUNT_W-1:0]          reload,
    output logic                        start,
    output logic                        load_wr
);
    import rtc_pkg::*;

    logic ctrl_wr;

    assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
    assign load_wr = reg_wr && (reg_addr == ADDR_LOAD);

    // A start is accepted only with a non-zero count that is not expiring.
    assign start = ctrl_wr && reg_wdata[BIT_RUN] && (count != '0) && !halt;

    // Control fields and run state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            rep <= 1'b0;
            oe  <= 1'b0;
            res <= '0;
        end else if (ctrl_wr) begin
            run <= start;
            rep <= reg_wdata[BIT_REP];
            oe  <= reg_wdata[BIT_OE];
            res <= reg_wdata[RES_LSB +: RES_W];
        end else if (halt) begin
            run <= 1'b0;
        end
    end

    // Stored load value used for presets and reloads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload <= '0;
        end else if (load_wr) begin
            reload <= reg_wdata[COUNT_W-1:0];
        end
    end

    // Read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[BIT_RUN]             = run;
                reg_rdata[BIT_REP]             = rep;
                reg_rdata[BIT_OE]              = oe;
                reg_rdata[RES_LSB +: RES_W]    = res;
            end
            ADDR_LOAD:  reg_rdata = DATA_W'(reload);
            ADDR_COUNT: reg_rdata = DATA_W'(count);
            default:    reg_rdata = '0;
        endcase
    end

    AST_NO_RUN_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (count != '0)); // R8
    AST_START_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ctrl_wr && reg_wdata[BIT_RUN] && !halt) |=> (run && count != '0)); // R9

endmodule

// File: rtl/rt_down_timer.sv
// Top of the prescaled real-time down counter: register block, prescaler and
// count core. Assumes CLK_FREQ_HZ is a whole multiple of 1 MHz and
// COUNT_W <= 32.
module rt_down_timer #(
    parameter int unsigned CLK_FREQ_HZ = 200_000_000,
    parameter int          COUNT_W     = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        out_strobe
);
    localparam int unsigned CYC_PER_US = CLK_FREQ_HZ / 1_000_000;

    logic                      run;
    logic                      rep;
    logic                      oe;
    logic [rtc_pkg::RES_W-1:0] res;
    logic [COUNT_W-1:0]        reload;
    logic [COUNT_W-1:0]        count;
    logic                      start;
    logic                      load_wr;
    logic                      halt;
    logic                      tick;

    rtc_ctrl_regs #(.COUNT_W(COUNT_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .count     (count),
        .halt      (halt),
        .run       (run),
        .rep       (rep),
        .oe        (oe),
        .res       (res),
        .reload    (reload),
        .start     (start),
        .load_wr   (load_wr)
    );

    rtc_prescale #(.CYC_PER_US(CYC_PER_US)) i_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .start (start),
        .res   (res),
        .tick  (tick)
    );

    rtc_count_core #(.COUNT_W(COUNT_W)) i_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .rep        (rep),
        .oe         (oe),
        .tick       (tick),
        .reload     (reload),
        .load_wr    (load_wr),
        .load_data  (reg_wdata[COUNT_W-1:0]),
        .count      (count),
        .halt       (halt),
        .irq        (irq),
        .out_strobe (out_strobe)
    );

endmodule

// File: tb/test_rt_down_timer.sv
`timescale 1ns/1ps
module test_rt_down_timer;
    localparam int unsigned FREQ = 2_000_000;   // 2 cycles per microsecond
    localparam int          CPU  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        out_strobe;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    rt_down_timer #(.CLK_FREQ_HZ(FREQ), .COUNT_W(16)) i_rt_down_timer (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .out_strobe(out_strobe)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    function automatic int period_of(input int code);
        int s = 1;
        if (code > 5) return CPU;
        for (int i = 0; i < code; i++) s = s * 10;
        return CPU * s;
    endfunction

    // Wait for irq; returns cycles waited or -1.
    task automatic wait_irq(input int limit, output int cyc);
        cyc = -1;
        for (int c = 1; c <= limit; c++) begin
            @(negedge clk);
            if (irq) begin cyc = c; break; end
        end
    endtask

    task automatic sweep(input int code, input int L);
        logic [31:0] v;
        int P = period_of(code);
        bit early = 0;
        wr(2'd1, 32'(L));
        wr(2'd0, (32'(code) << 20) | 32'h1);
        for (int c = 1; c <= L * P; c++) begin
            @(negedge clk);
            if (c < L * P && irq) early = 1;
            if (c == P - 1) begin rd(2'd2, v); chk(v == 32'(L), "R3 before first tick", v, L); end
            if (c == P && L > 1) begin rd(2'd2, v); chk(v == 32'(L - 1), "R2 first tick", v, L - 1); end
        end
        chk(!early, "R2 no early irq", early, 0);
        chk(irq == 1'b1, "R4 irq at L*period", irq, 1);
        rd(2'd2, v); chk(v == 0, "R5 count zero", v, 0);
        rd(2'd0, v); chk(v[0] == 1'b0, "R5 run cleared", v[0], 0);
        @(negedge clk);
        chk(irq == 1'b0, "R4 single cycle", irq, 0);
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        finish_up();
    end

    initial begin
        logic [31:0] v;
        int cyc;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk(v == 0, "R1 ctrl", v, 0);
        rd(2'd1, v); chk(v == 0, "R1 load", v, 0);
        rd(2'd2, v); chk(v == 0, "R1 count", v, 0);
        chk(irq == 0 && out_strobe == 0, "R1 outputs", {irq, out_strobe}, 0);

        // R11 map
        wr(2'd0, 32'hFFFF_FFFE);
        rd(2'd0, v); chk(v == 32'h0070_0006, "R11 ctrl fields", v, 32'h0070_0006);
        wr(2'd0, 32'h0);
        wr(2'd1, 32'd7);
        rd(2'd2, v); chk(v == 7, "R7 load presets count", v, 7);
        wr(2'd2, 32'd99);
        rd(2'd2, v); chk(v == 7, "R11 count read-only", v, 7);
        rd(2'd3, v); chk(v == 0, "R11 spare reads zero", v, 0);

        // R2 R4 R5 resolution sweep
        sweep(0, 3); sweep(1, 3); sweep(2, 3); sweep(3, 3);
        sweep(6, 3); sweep(7, 3); sweep(4, 1);

        // R2 code 5: no tick within 25000 cycles, then R3 stop holds
        wr(2'd1, 32'd1);
        wr(2'd0, (32'd5 << 20) | 32'h1);
        wait_irq(25000, cyc);
        chk(cyc == -1, "R2 code5 no early tick", cyc, -1);
        rd(2'd2, v); chk(v == 1, "R2 code5 count held", v, 1);
        wr(2'd0, 32'h0);
        repeat (10) @(negedge clk);
        rd(2'd2, v); chk(v == 1, "R3 stop holds", v, 1);

        // R3 stop and resume
        wr(2'd1, 32'd10);
        wr(2'd0, 32'h1);
        repeat (7) @(negedge clk);
        wr(2'd0, 32'h0);
        rd(2'd2, v); chk(v == 6, "R3 stopped value", v, 6);
        repeat (40) @(negedge clk);
        rd(2'd2, v); chk(v == 6, "R3 held while stopped", v, 6);
        wr(2'd0, 32'h1);
        wait_irq(100, cyc); chk(cyc == 12, "R3 resume continues", cyc, 12);
        @(negedge clk);

        // R6 repeat
        wr(2'd1, 32'd3);
        wr(2'd0, 32'h3);
        wait_irq(100, cyc); chk(cyc == 6, "R6 first period", cyc, 6);
        rd(2'd2, v); chk(v == 3, "R6 reloaded", v, 3);
        rd(2'd0, v); chk(v[0] == 1, "R6 still running", v[0], 1);
        wait_irq(100, cyc); chk(cyc == 6, "R6 second period", cyc, 6);
        wr(2'd1, 32'd5);
        rd(2'd2, v); chk(v == 3, "R7 load while running keeps count", v, 3);
        wait_irq(100, cyc); chk(cyc == 5, "R6 remaining period", cyc, 5);
        rd(2'd2, v); chk(v == 5, "R6 new reload", v, 5);
        wait_irq(100, cyc); chk(cyc == 10, "R6 new period", cyc, 10);
        wr(2'd1, 32'd0);
        wait_irq(100, cyc); chk(cyc == 9, "R6 zero reload event", cyc, 9);
        rd(2'd2, v); chk(v == 0, "R6 zero reload count", v, 0);
        rd(2'd0, v); chk(v[0] == 0, "R6 zero reload stops", v[0], 0);
        wait_irq(20, cyc); chk(cyc == -1, "R6 no further irq", cyc, -1);

        // R9 restart while running
        wr(2'd1, 32'd2);
        wr(2'd0, (32'd1 << 20) | 32'h1);
        repeat (10) @(negedge clk);
        wr(2'd0, (32'd1 << 20) | 32'h1);
        rd(2'd2, v); chk(v == 2, "R9 count unchanged", v, 2);
        wait_irq(100, cyc); chk(cyc == 40, "R9 prescaler restarted", cyc, 40);

        // R8 zero load refused
        wr(2'd1, 32'd0);
        wr(2'd0, 32'h1);
        rd(2'd0, v); chk(v[0] == 0, "R8 start refused", v[0], 0);
        wait_irq(30, cyc); chk(cyc == -1, "R8 no irq", cyc, -1);

        // R10 output enable
        wr(2'd1, 32'd2);
        wr(2'd0, 32'h5);
        wait_irq(100, cyc); chk(cyc == 4, "R10 period with oe", cyc, 4);
        chk(out_strobe == 1, "R10 strobe with oe", out_strobe, 1);
        @(negedge clk);
        chk(out_strobe == 0, "R10 strobe one cycle", out_strobe, 0);
        wr(2'd1, 32'd2);
        wr(2'd0, 32'h1);
        wait_irq(100, cyc); chk(cyc == 4, "R10 period without oe", cyc, 4);
        chk(out_strobe == 0, "R10 strobe gated", out_strobe, 0);

        finish_up();
    end
endmodule